// File: doc/BRIEF.md
# Down-Counting Interrupt Timer Channel

This block is one timer channel for a multiprocessor interrupt controller. Software programs a period into a base register. A hardware tick enable drives a current count down from that period. Each time the count runs out, the channel reloads the period by itself, inverts a toggle flag and raises a single-cycle interrupt request. Routing that request to a processor happens outside the block.

The base register carries a freeze flag in its top bit. While the flag is set the count holds its value on every tick. Clearing the flag with a register write arms a fresh load, so the first running tick copies the period into the count before any decrement takes place. If the toggle flag is set when that release write arrives, the same write clears it. This gives software a way to restart the flag's phase. The current count can only be read. Writes to it have no effect.

Top module: `tmr_channel`

## Requirements
- R1: While reset is held, and after it is released, offset 0 reads 0x0000_0000, offset 1 reads 0x8000_0000 and irq is low.
- R2: A write to offset 1 stores all 32 bits, and offset 1 then reads them back. Offset 0 reads the toggle flag in bit 31 and the count in bits 30:0. Any offset other than 0 and 1 reads 0.
- R3: Writes to offset 0 and writes to any offset of 2 or more change neither the count, the toggle flag nor the base register.
- R4: While bit 31 of the stored base value (freeze) is 1, ticks change neither the count nor the toggle flag.
- R5: The count changes only on clock edges where tick is high.
- R6: A write to offset 1 with bit 31 clear, arriving while the stored bit 31 is set, arms a load. The next running tick copies base bits 30:0 into the count and does not decrement.
- R7: A running tick with no load armed and a count of 2 or more lowers the count by exactly 1.
- R8: A running tick with no load armed and a count of 0 or 1 is an expiry. It reloads the count from base bits 30:0 and inverts the toggle flag. With base value N, expiries therefore come every N ticks, and every tick when N is 0.
- R9: irq is high during the one clock cycle that follows an expiry tick's edge, and low after a non-expiry edge.
- R10: A write to offset 1 clears the toggle flag only when three conditions hold together: the flag is 1, the stored bit 31 is 1, and the written bit 31 is 0. Every other write to offset 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word offset of the register access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Expiry interrupt pulse |

## Verification
A wrong count or a missing load shows up on the offset-0 readback on the first tick after the fault, because every running tick changes that value in a way the bench can predict. A lost or extra expiry shows up twice: the interval between irq pulses is off by the first period, and the toggle bit read at offset 0 has the wrong phase. A wrongly stored freeze flag or armed-load flag stays invisible until the next tick. That tick then either moves a value that should hold, or decrements where the period should have loaded. The sweeps therefore read the registers after every tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DEF_CNT_W  = 31;
    localparam int DEF_ADDR_W = 4;

    typedef enum logic [1:0] {
        SEL_CUR,
        SEL_BASE,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_LOAD,
        STEP_DEC,
        STEP_EXPIRE
    } step_e;

    // Choose what one clock edge does to the count.
    function automatic step_e pick_step(
        input logic tick,
        input logic frozen,
        input logic armed,
        input logic at_floor
    );
        if (!tick || frozen) return STEP_HOLD;
        if (armed)           return STEP_LOAD;
        if (at_floor)        return STEP_EXPIRE;
        return STEP_DEC;
    endfunction

endpackage

// File: rtl/tmr_base_reg.sv
module tmr_base_reg
    import tmr_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_base,
    input  logic [CNT_W:0]   wr_data,
    input  logic             tog_now,
    input  logic             load_taken,
    output logic [CNT_W:0]   base_q,
    output logic             armed,
    output logic             tog_clr
);
    localparam logic [CNT_W:0] BASE_RST = {1'b1, {CNT_W{1'b0}}};

    logic release_wr;

    always_comb begin
        release_wr = wr_base && base_q[CNT_W] && !wr_data[CNT_W];
        tog_clr    = release_wr && tog_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= BASE_RST;
            armed  <= 1'b0;
        end else begin
            if (wr_base) begin
                base_q <= wr_data;
            end
            if (release_wr) begin
                armed <= 1'b1;
            end else if (load_taken) begin
                armed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_down_count.sv
module tmr_down_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             frozen,
    input  logic             armed,
    input  logic [CNT_W-1:0] reload,
    input  logic             tog_clr,
    output logic [CNT_W-1:0] count,
    output logic             tog,
    output logic             irq,
    output logic             load_taken
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(1);

    step_e step;

    always_comb begin
        step       = pick_step(tick, frozen, armed, count <= FLOOR);
        load_taken = (step == STEP_LOAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            tog   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= (step == STEP_EXPIRE);
            unique case (step)
                STEP_LOAD:   count <= reload;
                STEP_DEC:    count <= count - FLOOR;
                STEP_EXPIRE: count <= reload;
                default:     count <= count;
            endcase
            if (step == STEP_EXPIRE) begin
                tog <= ~tog;
            end else if (tog_clr) begin
                tog <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W:0]    wr_data,
    output logic [CNT_W:0]    rd_data,
    output logic              irq
);
    localparam int DATA_W = CNT_W + 1;

    reg_sel_e          sel;
    logic              wr_base;
    logic [CNT_W:0]    base_word;
    logic [CNT_W:0]    cur_word;
    logic [CNT_W-1:0]  count;
    logic              tog;
    logic              armed;
    logic              tog_clr;
    logic              load_taken;

    always_comb begin
        if (addr == ADDR_W'(0))      sel = SEL_CUR;
        else if (addr == ADDR_W'(1)) sel = SEL_BASE;
        else                         sel = SEL_NONE;
        wr_base  = wr_en && (sel == SEL_BASE);
        cur_word = {tog, count};
    end

    tmr_base_reg #(.CNT_W(CNT_W)) u_base (
        .clk        (clk),
        .rst        (rst),
        .wr_base    (wr_base),
        .wr_data    (wr_data),
        .tog_now    (tog),
        .load_taken (load_taken),
        .base_q     (base_word),
        .armed      (armed),
        .tog_clr    (tog_clr)
    );

    tmr_down_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .frozen     (base_word[CNT_W]),
        .armed      (armed),
        .reload     (base_word[CNT_W-1:0]),
        .tog_clr    (tog_clr),
        .count      (count),
        .tog        (tog),
        .irq        (irq),
        .load_taken (load_taken)
    );

    always_comb begin
        unique case (sel)
            SEL_CUR:  rd_data = cur_word;
            SEL_BASE: rd_data = base_word;
            default:  rd_data = {DATA_W{1'b0}};
        endcase
    end

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic [CNT_W:0]    cur_val,
    input logic [CNT_W:0]    base_val
);
    localparam logic [CNT_W:0] BASE_RST = {1'b1, {CNT_W{1'b0}}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cur_val == '0 && base_val == BASE_RST && !irq));

    // R4
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        base_val[CNT_W] |=> $stable(cur_val[CNT_W-1:0]));

    // R5
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cur_val[CNT_W-1:0]));

    // R3
    cur_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(0) && !tick) |=> $stable(cur_val));

    // R9
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(tick));

    // R8
    toggle_rise_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cur_val[CNT_W]) |-> irq);

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .irq      (irq),
    .cur_val  (cur_word),
    .base_val (base_word)
);

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [31:0] FRZ = 32'h8000_0000;

    always #2.5 clk = ~clk;

    tmr_channel uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; addr = '0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rd_data;
        addr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        exp_tog;
        int          ticks;
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rd(4'd0, v); chk("R1 cur in reset", v, 32'h0);
        rd(4'd1, v); chk("R1 base in reset", v, FRZ);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd(4'd0, v); chk("R1 cur after reset", v, 32'h0);
        rd(4'd1, v); chk("R1 base after reset", v, FRZ);

        // R3: ignored writes
        do_write(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); chk("R3 write to cur ignored", v, 32'h0);
        do_write(4'd2, 32'h0000_0055);
        rd(4'd1, v); chk("R3 write to offset 2 ignored", v, FRZ);
        rd(4'd2, v); chk("R2 offset 2 reads zero", v, 32'h0);
        rd(4'd15, v); chk("R2 offset 15 reads zero", v, 32'h0);

        // R4: frozen from reset
        do_tick(); do_tick();
        rd(4'd0, v); chk("R4 frozen ticks hold count", v, 32'h0);
        chk("R9 no irq while frozen", {31'b0, irq}, 32'h0);

        // Sweep over periods
        exp_tog = 1'b0;
        for (int n = 0; n <= 6; n++) begin
            do_write(4'd1, FRZ | n);
            rd(4'd0, v); chk("R10 freeze write keeps toggle", {31'b0, v[31]}, {31'b0, exp_tog});
            do_write(4'd1, n);
            rd(4'd1, v); chk("R2 base readback", v, n);
            rd(4'd0, v); chk("R10 release clears toggle", {31'b0, v[31]}, 32'h0);
            do_tick();
            rd(4'd0, v); chk("R6 armed load on first tick", v, n);
            chk("R9 no irq on load tick", {31'b0, irq}, 32'h0);
            ticks = 0;
            for (int k = 0; k < 20; k++) begin
                do_tick();
                ticks++;
                if (irq) break;
                rd(4'd0, v); chk("R7 decrement by one", v, n - ticks);
            end
            chk("R8 expiry period", ticks, (n == 0) ? 1 : n);
            rd(4'd0, v); chk("R8 reload and toggle", v, FRZ | n);
            @(negedge clk);
            chk("R9 irq one cycle", {31'b0, irq}, 32'h0);
            exp_tog = 1'b1;
        end

        // State: base 6, count 6, toggle 1, running
        do_tick();
        rd(4'd0, v); chk("R7 decrement after reload", v, FRZ | 32'd5);
        repeat (3) @(negedge clk);
        rd(4'd0, v); chk("R5 idle cycles hold count", v, FRZ | 32'd5);

        // R10 negative cases
        do_write(4'd1, 32'd4);
        rd(4'd0, v); chk("R10 running write keeps toggle", v, FRZ | 32'd5);
        do_tick();
        rd(4'd0, v); chk("R6 no load without release", v, FRZ | 32'd4);
        do_write(4'd1, FRZ | 32'd4);
        rd(4'd0, v); chk("R10 freezing write keeps toggle", v, FRZ | 32'd4);
        do_tick(); do_tick(); do_tick();
        rd(4'd0, v); chk("R4 frozen mid-count", v, FRZ | 32'd4);
        do_write(4'd0, 32'h0000_0001);
        rd(4'd0, v); chk("R3 cur write while frozen", v, FRZ | 32'd4);
        do_write(4'd1, 32'd4);
        rd(4'd0, v); chk("R10 release clears toggle mid-count", v, 32'd4);
        do_tick();
        rd(4'd0, v); chk("R6 load instead of decrement", v, 32'd4);
        do_tick();
        rd(4'd0, v); chk("R7 decrement after load", v, 32'd3);

        // R2 full-width readback
        do_write(4'd1, 32'hDEAD_BEEF);
        rd(4'd1, v); chk("R2 base full width", v, 32'hDEAD_BEEF);
        rd(4'd0, v); chk("R4 freeze via readback write", v, 32'd3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule